// File: doc/BRIEF.md
# Real-Time Clock Host Register Port

This block is the processor-facing side of a battery-backed real-time clock. Software reaches a 128-byte register space through two byte-wide addresses. A write to the even address selects a byte. Reads and writes at the odd address then reach that selected byte.

Four of the bytes are control and status registers rather than plain storage:
- register A holds the divider and rate settings, plus an update-busy bit;
- register B holds the interrupt enables and the set mode;
- register C holds the interrupt flags;
- register D is a fixed status byte.

The block combines flag requests from the periodic, alarm and update logic with the enables in register B. From them it drives one level-sensitive interrupt line. Reading register C acknowledges all pending flags and drops that line.

It also tells the timekeeping logic two things. It reports whether the clock is running. It pulses a strobe when the divider is released from reset, so that the first update can be placed half a second later.

Top module: `rtc_regport`

## Requirements
- R1: A write at the even address loads the index with the low 7 bits of the data (bit 7 is discarded). Odd-address accesses to any index outside 10..13 read or write a plain storage byte at that index.
- R2: A read at the even address returns 0xFF.
- R3: Writes to register C (index 12) and register D (index 13) have no effect. Register D always reads 0x80.
- R4: Register A (index 10) bits 6:0 are writable, and bit 7 ignores written data.
- R5: Register A bit 7 (update busy) reads 1 only while the clock is running and `upd_busy` is high.
- R6: Reading register C returns its current value. From the next cycle C is 0x00 and `irq` is low. A flag request arriving in the read cycle is kept, not lost.
- R7: Register C bits are PF = 6, AF = 5, UF = 4 and the master flag IRQF = 7. The matching enables in register B are bits 6, 5 and 4. A flag request sets its flag one cycle later. If its enable is 1 and the flag was clear, IRQF and `irq` also go high in that cycle.
- R8: On a write to register B (index 11), IRQF and `irq` become 1 if any written enable in bits 6:4 matches a pending flag, and otherwise become 0.
- R9: Hard reset gives A = 0x26, B = 0x02, C = 0x00 and D = 0x80. `soft_rst` clears B bits 6, 5 and 3, clears all of C, and lowers `irq`.
- R10: `run_en` is 1 when B bit 7 (SET) is 0 and A bits 6:4 are 010 or less. `div_restart` pulses for one cycle after a write to A that moves A bits 6:5 from 11 to bits 6:4 of at most 010 while SET is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| soft_rst | input | 1 | Later reset: clears enables and flags |
| cs | input | 1 | Access strobe, one cycle per byte access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| set_pf | input | 1 | Periodic flag request |
| set_af | input | 1 | Alarm flag request |
| set_uf | input | 1 | Update-ended flag request |
| upd_busy | input | 1 | High in the last 8 ticks of 32768 Hz before each update |
| irq | output | 1 | Level interrupt |
| run_en | output | 1 | Clock running |
| div_restart | output | 1 | One-cycle strobe on divider release |

## Verification
The bench builds the block with the default 7-bit index. This gives it the full 128-byte space, so it can write an index with bit 7 set and see that the bit is dropped. It can also probe the control window at indices 10 to 13 alongside plain storage. Every flag and enable pairing is within reach. The bench covers a request with its enable off and with it on, an enable written after its flag is already pending, an enable cleared while its flag stays pending, and the two reset kinds.

// File: rtl/rtc_regport.sv
module rtc_regport #(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cs,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       set_pf,
  input  logic       set_af,
  input  logic       set_uf,
  input  logic       upd_busy,
  output logic       irq,
  output logic       run_en,
  output logic       div_restart
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IX_A = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_B = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_C = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_D = IDX_W'(13);

  logic [IDX_W-1:0] idx;
  logic [6:0]       areg;
  logic [7:0]       breg, creg;
  logic [7:0]       mem [DEPTH];
  logic             restart_q;

  logic       wr_idx, wr_dat, rd_dat, wr_a, wr_b, rd_c, special;
  logic [7:0] c_base, c_next;
  logic [2:0] req, flags;
  logic       irqf;

  assign wr_idx  = cs & we & ~addr;
  assign wr_dat  = cs & we & addr;
  assign rd_dat  = cs & ~we & addr;
  assign wr_a    = wr_dat && idx == IX_A;
  assign wr_b    = wr_dat && idx == IX_B;
  assign rd_c    = rd_dat && idx == IX_C;
  assign special = idx >= IX_A && idx <= IX_D;

  assign run_en      = ~breg[7] && areg[6:4] <= 3'b010;
  assign irq         = creg[7];
  assign div_restart = restart_q;

  always_comb begin
    c_base = rd_c ? 8'h00 : creg;
    req    = {set_pf, set_af, set_uf};
    flags  = c_base[6:4] | req;
    if (wr_b) irqf = |(wdata[6:4] & flags);
    else      irqf = c_base[7] | (|(req & ~c_base[6:4] & breg[6:4]));
    c_next = {irqf, flags, 4'h0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      areg      <= 7'h26;
      breg      <= 8'h02;
      creg      <= 8'h00;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (wr_idx) idx <= wdata[IDX_W-1:0];
      if (wr_a) begin
        areg      <= wdata[6:0];
        restart_q <= areg[6:5] == 2'b11 && wdata[6:4] <= 3'b010 && ~breg[7];
      end
      if (soft_rst) begin
        breg <= breg & 8'h97;
        creg <= 8'h00;
      end else begin
        creg <= c_next;
        if (wr_b) breg <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_dat && !special) mem[idx] <= wdata;
  end

  always_comb begin
    if (!addr) rdata = 8'hFF;
    else begin
      case (idx)
        IX_A:    rdata = {run_en & upd_busy, areg};
        IX_B:    rdata = breg;
        IX_C:    rdata = creg;
        IX_D:    rdata = 8'h80;
        default: rdata = mem[idx];
      endcase
    end
  end
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             cs,
  input logic             we,
  input logic             addr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             set_pf,
  input logic             set_af,
  input logic             set_uf,
  input logic             irq,
  input logic             run_en,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       breg
);
  logic rd_odd, rd_c, wr_b;
  assign rd_odd = cs && !we && addr;
  assign rd_c   = rd_odd && idx == IDX_W'(12);
  assign wr_b   = cs && we && addr && idx == IDX_W'(11);

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && !addr) |=> idx == $past(wdata[IDX_W-1:0]));

  // R2
  even_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && !addr) |-> rdata == 8'hFF);

  // R3
  d_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_odd && idx == IDX_W'(13)) |-> rdata == 8'h80);

  // R5
  uip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_odd && idx == IDX_W'(10) && !run_en) |-> !rdata[7]);

  // R6
  c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !set_pf && !set_af && !set_uf) |=> !irq);

  // R7
  flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !rd_c && !wr_b && set_uf && breg[4]) |=> irq);
endmodule

bind rtc_regport rtc_regport_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cs(cs), .we(we),
  .addr(addr), .wdata(wdata), .rdata(rdata), .set_pf(set_pf),
  .set_af(set_af), .set_uf(set_uf), .irq(irq), .run_en(run_en),
  .idx(idx), .breg(breg)
);

// File: tb/sim_rtc_regport.sv
module sim_rtc_regport;
  logic clk = 0, rst_n = 0, soft_rst = 0, cs = 0, we = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic set_pf = 0, set_af = 0, set_uf = 0, upd_busy = 0;
  logic [7:0] rdata;
  logic irq, run_en, div_restart;
  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rtc_regport u0 (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cs(cs),
    .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .set_pf(set_pf),
    .set_af(set_af), .set_uf(set_uf), .upd_busy(upd_busy), .irq(irq),
    .run_en(run_en), .div_restart(div_restart));

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (cs && !we) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s read: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic bus(input logic w, input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    cs = 1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 0; we = 0;
  endtask

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
    bus(1, 0, ix);
    bus(1, 1, d);
  endtask

  task automatic rd_reg(input logic [7:0] ix, input logic [7:0] e, input string t);
    bus(1, 0, ix);
    exp_q.push_back(e); tag_q.push_back(t);
    bus(0, 1, 8'h00);
  endtask

  task automatic chk(input logic got, input logic e, input string t);
    tests++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: got %b expected %b", t, got, e);
    end
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    set_pf = (which == 0); set_af = (which == 1); set_uf = (which == 2);
    @(posedge clk); #1;
    set_pf = 0; set_af = 0; set_uf = 0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset defaults
    chk(irq, 0, "R9 irq after reset");
    rd_reg(8'd10, 8'h26, "R9 A default");
    rd_reg(8'd11, 8'h02, "R9 B default");
    rd_reg(8'd12, 8'h00, "R9 C default");
    rd_reg(8'd13, 8'h80, "R9 D default");
    // R2 even read
    exp_q.push_back(8'hFF); tag_q.push_back("R2 even read");
    bus(0, 0, 8'h00);
    // R1 index masking and storage
    wr_reg(8'h85, 8'h5A);
    rd_reg(8'h05, 8'h5A, "R1 masked index");
    wr_reg(8'h7F, 8'hC3);
    rd_reg(8'h7F, 8'hC3, "R1 top byte");
    // R3 read-only C and D
    wr_reg(8'd12, 8'hFF);
    rd_reg(8'd12, 8'h00, "R3 C write ignored");
    chk(irq, 0, "R3 irq after C write");
    wr_reg(8'd13, 8'h00);
    rd_reg(8'd13, 8'h80, "R3 D write ignored");
    // R4 / R5 update-busy bit
    wr_reg(8'd10, 8'hA5);
    rd_reg(8'd10, 8'h25, "R4 bit7 not written");
    upd_busy = 1;
    rd_reg(8'd10, 8'hA5, "R5 busy while running");
    wr_reg(8'd10, 8'h70);
    chk(run_en, 0, "R10 divider held");
    rd_reg(8'd10, 8'h70, "R5 busy hidden when stopped");
    // R10 divider release strobe
    bus(1, 1, 8'h26);
    chk(div_restart, 1, "R10 restart pulse");
    chk(run_en, 1, "R10 running again");
    @(posedge clk); #1;
    chk(div_restart, 0, "R10 pulse one cycle");
    upd_busy = 0;
    // R7 flag without enable
    pulse(0);
    chk(irq, 0, "R7 PF no enable");
    rd_reg(8'd12, 8'h40, "R7 PF flag only");
    rd_reg(8'd12, 8'h00, "R6 C cleared");
    // R7 / R6 with enable
    wr_reg(8'd11, 8'h12);
    pulse(2);
    chk(irq, 1, "R7 UF with enable");
    rd_reg(8'd12, 8'h90, "R6 C value returned");
    chk(irq, 0, "R6 irq dropped");
    // R8 enable after pending
    wr_reg(8'd11, 8'h02);
    pulse(1);
    chk(irq, 0, "R8 AF pending, disabled");
    wr_reg(8'd11, 8'h22);
    chk(irq, 1, "R8 enable raises irq");
    rd_reg(8'd12, 8'hA0, "R8 C after enable");
    wr_reg(8'd11, 8'h42);
    pulse(0);
    chk(irq, 1, "R7 PF with enable");
    wr_reg(8'd11, 8'h02);
    chk(irq, 0, "R8 disable lowers irq");
    rd_reg(8'd12, 8'h40, "R8 IRQF cleared, PF kept");
    // R9 soft reset
    wr_reg(8'd11, 8'h7A);
    pulse(2);
    chk(irq, 1, "R9 irq before soft reset");
    @(posedge clk); #1 soft_rst = 1;
    @(posedge clk); #1 soft_rst = 0;
    chk(irq, 0, "R9 soft reset lowers irq");
    rd_reg(8'd11, 8'h12, "R9 B enables cleared");
    rd_reg(8'd12, 8'h00, "R9 C cleared");
    // R10 SET stops clock
    wr_reg(8'd11, 8'h82);
    chk(run_en, 0, "R10 SET stops");
    upd_busy = 1;
    rd_reg(8'd10, 8'h26, "R5 busy hidden in set mode");
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule